// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-wire serial link into a bank of sixteen byte-wide registers. The host raises a chip enable and clocks bits in on a shift clock. The host drives the shared data line through `sdi_i`. The block answers on `sdo_o`, qualified by `sdo_oe_o`, which drives the pad's tri-state control. The block oversamples the three serial inputs with its own system clock through a synchronizer. It acts only on rising shift-clock edges that it sees while chip enable is high.

Every transaction has the same layout: a 4-bit operation code, then a 4-bit starting register address, then any number of data bytes. All fields travel least significant bit first. The register bank itself sits outside the block. Writes reach it as a one-cycle strobe with an address and a byte. Reads are served by a combinational lookup on `rd_addr_o` that returns `rd_data_i`. The block also emits a pulse on every chip-enable release, which the bank uses to clear its volatile control bits. A second pulse reports a write byte that was cut short.

Top module: `tw_port`

## Requirements
- R1: After reset, `sdo_oe_o`, `wr_en_o`, `write_fail_o` and `ctl_clear_o` are all low.
- R2: Operation code 3 selects write. The code is sent as bits 1,1,0,0 on successive rising shift-clock edges. Each complete byte that follows produces one single-cycle `wr_en_o` pulse. The byte is assembled LSB first. The pulse carries the address taken from the address nibble, which is also sent LSB first.
- R3: After each complete write byte the address advances by one, so successive bytes land at N, N+1, and so on. Address 0 follows address F.
- R4: Operation code C (bits 0,0,1,1) selects read. Once the address nibble is complete, `sdo_oe_o` rises and `sdo_o` shows bit 0 of the addressed register before the next rising shift-clock edge. Each rising edge then presents the next bit.
- R5: In read mode the address advances after every eight bits. The next register's bit 0 is presented at once, and address F is followed by address 0.
- R6: Any other operation code makes the rest of the transaction a no-op: no write strobe, and `sdo_oe_o` stays low until chip enable is released.
- R7: If chip enable is released part way through a write data byte, that byte is not written. Bytes already completed remain written, and `write_fail_o` pulses for one cycle.
- R8: Every release of chip enable, whatever the mode, produces exactly one single-cycle `ctl_clear_o` pulse.
- R9: While chip enable is low, `sdo_oe_o` is low and shift-clock edges are ignored. Each new transaction starts again with the operation code.
- R10: `write_fail_o` stays low when chip enable is released on a byte boundary, in read mode, or in an ignored transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable, active high |
| sclk_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Output enable for the data pad |
| wr_en_o | output | 1 | Register write strobe, one cycle |
| wr_addr_o | output | 4 | Register write address |
| wr_data_o | output | 8 | Register write data |
| rd_addr_o | output | 4 | Register read address |
| rd_data_i | input | 8 | Register read data for `rd_addr_o` |
| write_fail_o | output | 1 | Pulse: a write byte was truncated |
| ctl_clear_o | output | 1 | Pulse: chip enable was released |

## Verification
Assertions watch several relations on every cycle. Write strobes appear only in the write state, and the address moves exactly one step past each strobe. Each read reload steps the read address by one. The output enable falls once chip enable is seen low. A failure pulse never appears without the matching release pulse. The scenarios must show the rest. These are the LSB-first assembly of the code, the address and the data, and the bit order seen on the data line. They also include wrap-around from F to 0, silence after illegal codes, and the fact that a truncated byte never reaches the bank. Only a full transaction driven against a model bank exposes those.

// File: rtl/tw_port_pkg.sv
package tw_port_pkg;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam logic [NIB_W-1:0] OP_WRITE = 4'h3;
  localparam logic [NIB_W-1:0] OP_READ  = 4'hC;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_IGNORE
  } port_st_e;
endpackage

// File: rtl/tw_rst_sync.sv
module tw_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= 2'b00;
    else         chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_no = chain_q[1];
endmodule

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import tw_port_pkg::*;
#(
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              ce_fall,
  input  logic              sclk_rise,
  input  logic              sdi_s,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_load_o,
  output logic              rd_shift_o,
  output logic              oe_o,
  output logic              write_fail_o,
  output logic              ctl_clear_o
);
  localparam logic [CNT_W-1:0] NIB_LAST  = CNT_W'(NIB_W - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);

  port_st_e          state_q, state_d;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [DATA_W-1:0] sh_q, sh_d, shifted;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              is_wr_q, is_wr_d;
  logic              wr_en_q, wr_en_d;
  logic [ADDR_W-1:0] wr_addr_q, wr_addr_d;
  logic [DATA_W-1:0] wr_data_q, wr_data_d;
  logic [ADDR_W-1:0] rd_addr_q, rd_addr_d;
  logic              load_q, load_d;
  logic              shift_q, shift_d;
  logic              fail_q, fail_d;
  logic              clr_q, clr_d;
  logic [NIB_W-1:0]  nibble;

  assign shifted = {sdi_s, sh_q[DATA_W-1:1]};
  assign nibble  = shifted[DATA_W-1 -: NIB_W];

  always_comb begin
    state_d   = state_q;
    bitcnt_d  = bitcnt_q;
    sh_d      = sh_q;
    addr_d    = addr_q;
    is_wr_d   = is_wr_q;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr_q;
    wr_data_d = wr_data_q;
    rd_addr_d = rd_addr_q;
    load_d    = 1'b0;
    shift_d   = 1'b0;
    fail_d    = 1'b0;
    clr_d     = 1'b0;
    if (ce_fall) begin
      clr_d    = 1'b1;
      fail_d   = (state_q == ST_WRITE) && (bitcnt_q != '0);
      state_d  = ST_OPCODE;
      bitcnt_d = '0;
    end else if (!ce_s) begin
      state_d  = ST_OPCODE;
      bitcnt_d = '0;
    end else if (sclk_rise) begin
      sh_d     = shifted;
      bitcnt_d = bitcnt_q + 1'b1;
      unique case (state_q)
        ST_OPCODE: begin
          if (bitcnt_q == NIB_LAST) begin
            bitcnt_d = '0;
            if (nibble == OP_WRITE) begin
              state_d = ST_ADDR;
              is_wr_d = 1'b1;
            end else if (nibble == OP_READ) begin
              state_d = ST_ADDR;
              is_wr_d = 1'b0;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        ST_ADDR: begin
          if (bitcnt_q == NIB_LAST) begin
            bitcnt_d = '0;
            addr_d   = nibble;
            if (is_wr_q) begin
              state_d = ST_WRITE;
            end else begin
              state_d   = ST_READ;
              rd_addr_d = nibble;
              load_d    = 1'b1;
            end
          end
        end
        ST_WRITE: begin
          if (bitcnt_q == BYTE_LAST) begin
            wr_en_d   = 1'b1;
            wr_addr_d = addr_q;
            wr_data_d = shifted;
            addr_d    = addr_q + 1'b1;
          end
        end
        ST_READ: begin
          if (bitcnt_q == BYTE_LAST) begin
            addr_d    = addr_q + 1'b1;
            rd_addr_d = addr_q + 1'b1;
            load_d    = 1'b1;
          end else begin
            shift_d = 1'b1;
          end
        end
        default: begin
          bitcnt_d = bitcnt_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_OPCODE;
      bitcnt_q  <= '0;
      sh_q      <= '0;
      addr_q    <= '0;
      is_wr_q   <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      rd_addr_q <= '0;
      load_q    <= 1'b0;
      shift_q   <= 1'b0;
      fail_q    <= 1'b0;
      clr_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      bitcnt_q  <= bitcnt_d;
      sh_q      <= sh_d;
      addr_q    <= addr_d;
      is_wr_q   <= is_wr_d;
      wr_en_q   <= wr_en_d;
      wr_addr_q <= wr_addr_d;
      wr_data_q <= wr_data_d;
      rd_addr_q <= rd_addr_d;
      load_q    <= load_d;
      shift_q   <= shift_d;
      fail_q    <= fail_d;
      clr_q     <= clr_d;
    end
  end

  assign wr_en_o      = wr_en_q;
  assign wr_addr_o    = wr_addr_q;
  assign wr_data_o    = wr_data_q;
  assign rd_addr_o    = rd_addr_q;
  assign rd_load_o    = load_q;
  assign rd_shift_o   = shift_q;
  assign oe_o         = (state_q == ST_READ);
  assign write_fail_o = fail_q;
  assign ctl_clear_o  = clr_q;

  // R2: a write strobe only follows a cycle spent in the write state
  assert_strobe_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> ($past(state_q) == ST_WRITE));

  // R3: the running address sits one past the address just strobed
  assert_addr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (addr_q == wr_addr_q + 1'b1));

  // R5: each reload inside a read stream steps the read address by one
  assert_read_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q && ($past(state_q) == ST_READ)) |-> (rd_addr_q == $past(rd_addr_q) + 1'b1));

  // R6: an ignored transaction never produces a write strobe
  assert_ignore_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |=> !wr_en_q);

  // R7: a truncation report always comes with a release pulse
  assert_fail_with_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> clr_q);

  // R9: with chip enable low the pad is released on the next cycle
  assert_oe_off_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> !oe_o);
endmodule

// File: rtl/tw_rd_shift.sv
module tw_rd_shift
  import tw_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              bit_o
);
  logic [DATA_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (load)       word_d = din;
    else if (shift) word_d = {1'b0, word_q[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign bit_o = word_q[0];

  // R4: load and shift requests never collide
  assert_load_shift_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));
endmodule

// File: rtl/tw_port.sv
module tw_port
  import tw_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              write_fail_o,
  output logic              ctl_clear_o
);
  logic       rst_n;
  logic [2:0] pins_s;
  logic       ce_s, sclk_s, sdi_s;
  logic       ce_d_q, sclk_d_q;
  logic       ce_fall, sclk_rise;
  logic       rd_load, rd_shift, oe, rd_bit;

  tw_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ce_i, sclk_i, sdi_i}),
    .q     (pins_s)
  );

  assign {ce_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d_q   <= 1'b0;
      sclk_d_q <= 1'b0;
    end else begin
      ce_d_q   <= ce_s;
      sclk_d_q <= sclk_s;
    end
  end

  assign ce_fall   = ce_d_q & ~ce_s;
  assign sclk_rise = sclk_s & ~sclk_d_q & ce_s;

  tw_frame u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_s         (ce_s),
    .ce_fall      (ce_fall),
    .sclk_rise    (sclk_rise),
    .sdi_s        (sdi_s),
    .wr_en_o      (wr_en_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .rd_addr_o    (rd_addr_o),
    .rd_load_o    (rd_load),
    .rd_shift_o   (rd_shift),
    .oe_o         (oe),
    .write_fail_o (write_fail_o),
    .ctl_clear_o  (ctl_clear_o)
  );

  tw_rd_shift u_rd_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rd_load),
    .shift (rd_shift),
    .din   (rd_data_i),
    .bit_o (rd_bit)
  );

  assign sdo_oe_o = oe;
  assign sdo_o    = oe & rd_bit;

  // R8: release pulses are single-cycle
  assert_clear_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clear_o |=> !ctl_clear_o);

  // R10: no truncation report while the port is still selected
  assert_fail_only_on_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    write_fail_o |-> !ce_s);
endmodule

// File: tb/tw_port_bench.sv
module tw_port_bench;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic       sdo, sdo_oe, wr_en, write_fail, ctl_clear;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] bank [16];
  logic [7:0] expv [16];
  int errors = 0, checks = 0;
  int wr_cnt = 0, fail_cnt = 0, clr_cnt = 0;
  logic oe_seen = 1'b0;
  logic oe_clear = 1'b0;

  always #10 clk = ~clk;

  tw_port u_tw_port (
    .clk(clk), .rst_ni(rst_ni), .ce_i(ce), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .write_fail_o(write_fail), .ctl_clear_o(ctl_clear)
  );

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < 16; i++) bank[i] <= 8'(i * 17 + 3);
    end else if (wr_en) begin
      bank[wr_addr] <= wr_data;
    end
    if (wr_en) wr_cnt <= wr_cnt + 1;
    if (write_fail) fail_cnt <= fail_cnt + 1;
    if (ctl_clear) clr_cnt <= clr_cnt + 1;
    if (oe_clear) oe_seen <= 1'b0;
    else if (sdo_oe) oe_seen <= 1'b1;
  end
  assign rd_data = bank[rd_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    sdi = b; sclk = 1'b0;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic snib(input logic [3:0] n);
    for (int i = 0; i < 4; i++) sbit(n[i]);
  endtask

  task automatic sbyte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) sbit(b[i]);
  endtask

  task automatic rbyte(output logic [7:0] r);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0;
      wait_clk(HALF);
      r[i] = sdo;
      sclk = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic ce_on();
    ce = 1'b1; sclk = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic ce_off();
    sclk = 1'b0;
    wait_clk(HALF);
    ce = 1'b0;
    wait_clk(4 * HALF);
  endtask

  task automatic clear_oe_flag();
    oe_clear = 1'b1; wait_clk(1); oe_clear = 1'b0; wait_clk(1);
  endtask

  task automatic cmp_bank(input string req);
    for (int i = 0; i < 16; i++) chk(bank[i] == expv[i], req, bank[i], expv[i]);
  endtask

  task automatic t_reset();
    chk(sdo_oe == 1'b0, "R1 oe", sdo_oe, 0);
    chk(wr_en == 1'b0, "R1 wr_en", wr_en, 0);
    chk(write_fail == 1'b0, "R1 fail", write_fail, 0);
    chk(ctl_clear == 1'b0, "R1 clear", ctl_clear, 0);
  endtask

  task automatic t_write_single();
    int w0 = wr_cnt, c0 = clr_cnt, f0 = fail_cnt;
    ce_on(); snib(4'h3); snib(4'h5); sbyte(8'hA7); ce_off();
    expv[5] = 8'hA7;
    chk(wr_cnt - w0 == 1, "R2 strobe count", wr_cnt - w0, 1);
    chk(clr_cnt - c0 == 1, "R8 clear count", clr_cnt - c0, 1);
    chk(fail_cnt == f0, "R10 no fail on boundary", fail_cnt - f0, 0);
    cmp_bank("R2 bank");
  endtask

  task automatic t_write_wrap();
    int w0 = wr_cnt;
    ce_on(); snib(4'h3); snib(4'hE);
    sbyte(8'h11); sbyte(8'h22); sbyte(8'h33); ce_off();
    expv[14] = 8'h11; expv[15] = 8'h22; expv[0] = 8'h33;
    chk(wr_cnt - w0 == 3, "R3 strobe count", wr_cnt - w0, 3);
    cmp_bank("R3 bank");
  endtask

  task automatic t_read_single();
    logic [7:0] r;
    int f0 = fail_cnt;
    clear_oe_flag();
    ce_on(); snib(4'hC); snib(4'h5);
    chk(sdo_oe == 1'b1, "R4 oe after header", sdo_oe, 1);
    rbyte(r); ce_off();
    chk(r == expv[5], "R4 read data", r, expv[5]);
    chk(sdo_oe == 1'b0, "R9 oe after release", sdo_oe, 0);
    chk(fail_cnt == f0, "R10 no fail in read", fail_cnt - f0, 0);
  endtask

  task automatic t_read_wrap();
    logic [7:0] r0, r1, r2;
    ce_on(); snib(4'hC); snib(4'hF);
    rbyte(r0); rbyte(r1); rbyte(r2); ce_off();
    chk(r0 == expv[15], "R5 read F", r0, expv[15]);
    chk(r1 == expv[0], "R5 read 0", r1, expv[0]);
    chk(r2 == expv[1], "R5 read 1", r2, expv[1]);
  endtask

  task automatic t_bad_code(input logic [3:0] code);
    int w0 = wr_cnt, f0 = fail_cnt, c0 = clr_cnt;
    clear_oe_flag();
    ce_on(); snib(code); snib(4'h2); sbyte(8'hFF); sbit(1'b1); ce_off();
    chk(wr_cnt == w0, "R6 no strobe", wr_cnt - w0, 0);
    chk(oe_seen == 1'b0, "R6 oe stays low", oe_seen, 0);
    chk(fail_cnt == f0, "R10 no fail when ignored", fail_cnt - f0, 0);
    chk(clr_cnt - c0 == 1, "R8 clear when ignored", clr_cnt - c0, 1);
    cmp_bank("R6 bank");
  endtask

  task automatic t_truncate();
    int w0 = wr_cnt, f0 = fail_cnt;
    ce_on(); snib(4'h3); snib(4'h8);
    sbyte(8'h5A); sbit(1'b1); sbit(1'b0); sbit(1'b1); ce_off();
    expv[8] = 8'h5A;
    chk(wr_cnt - w0 == 1, "R7 only full byte", wr_cnt - w0, 1);
    chk(fail_cnt - f0 == 1, "R7 fail pulse", fail_cnt - f0, 1);
    cmp_bank("R7 bank");
  endtask

  task automatic t_idle_edges();
    int w0 = wr_cnt;
    clear_oe_flag();
    for (int i = 0; i < 12; i++) sbit(i[0] | i[1]);
    wait_clk(2 * HALF);
    chk(wr_cnt == w0, "R9 edges ignored", wr_cnt - w0, 0);
    chk(oe_seen == 1'b0, "R9 oe idle", oe_seen, 0);
    ce_on(); snib(4'h3); snib(4'h4); sbyte(8'hC3); ce_off();
    expv[4] = 8'hC3;
    chk(wr_cnt - w0 == 1, "R9 fresh transaction", wr_cnt - w0, 1);
    cmp_bank("R9 bank");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) expv[i] = 8'(i * 17 + 3);
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(5);
    t_reset();
    t_write_single();
    t_write_wrap();
    t_read_single();
    t_read_wrap();
    t_bad_code(4'h5);
    t_bad_code(4'hA);
    t_truncate();
    t_idle_edges();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule